// File: doc/BRIEF.md
# Monitor Threshold Alarm and Warning Flags

This block turns a stream of calibrated monitor readings into alarm and warning flag bytes for a dual-transmitter optical module. It watches six channels: die temperature, supply voltage, and a bias monitor and a power monitor for each of the two transmitters. Each reading arrives as a one-cycle strobe with a channel number and a 16-bit value. The block shifts the value right where that is configured, stores it, and compares it against four thresholds: alarm high, alarm low, warning high and warning low. Only the addressed channel's flags and stored reading change.

For each transmitter the flags are gathered into one alarm byte and one warning byte. The temperature and supply bits are shared by both transmitters. The bias and power bits belong to that transmitter alone. A per-transmitter ready nibble shows which channels have completed at least one conversion since reset. Each flag byte is ANDed with its own 8-bit enable mask and then ORed into a fault request. The request can be made sticky per transmitter, separately for alarms and for warnings.

Top module: `mon_thresh_flags`

## Requirements
- R1: A strobe changes only the flags, stored reading and ready bit of the channel it names. Channel codes are 0 temperature, 1 supply, 2 bias of transmitter 0, 3 power of transmitter 0, 4 bias of transmitter 1 and 5 power of transmitter 1. Codes 6 and 7 leave every output unchanged.
- R2: Temperature readings and thresholds are compared as signed two's complement numbers.
- R3: Supply, bias and power readings and thresholds are compared as unsigned numbers.
- R4: A high flag is 1 only when the reading is strictly greater than its high threshold; a reading equal to the threshold gives 0. The 16-bit threshold slot k of channel c is thr_cfg[(4c+k)*16 +: 16], with k = 0 alarm high and k = 2 warning high.
- R5: A low flag is 1 only when the reading is strictly less than its low threshold; a reading equal to the threshold gives 0. Slot k = 1 holds the alarm low threshold and k = 3 the warning low threshold.
- R6: For transmitter t, byte t of alarm_flags and of warn_flags holds, from bit 7 down to bit 0: temperature high, temperature low, supply high, supply low, bias-t high, bias-t low, power-t high, power-t low.
- R7: A bias or power reading is shifted right, before it is stored and compared, by a 3-bit count taken from rshift_cfg. The fields are [2:0] bias 0, [5:3] power 0, [8:6] bias 1 and [11:9] power 1. Temperature and supply readings are never shifted. mon_values[c*16 +: 16] holds the stored reading of channel c.
- R8: Ready bits are 0 after reset, set on the first conversion of their channel and stay set. The nibble of transmitter t, ready_flags[4t+3:4t], is {temperature, supply, bias t, power t}.
- R9: alarm_req[t] is 1 whenever alarm byte t ANDed with alarm_en[8t+7:8t] is non-zero, and warn_req[t] follows the same rule with warn_en. An enable bit of 0 stops its flag from raising the request.
- R10: When alarm_latch[t] (or warn_latch[t]) is 1, a request that has been raised stays 1 after the flags clear, until req_clr[t] is pulsed. When the latch bit is 0, the request follows the masked flags.
- R11: Synchronous reset clears all flags, stored readings, ready bits and requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| conv_stb | input | 1 | A conversion result is present this cycle |
| conv_chan | input | 3 | Channel code of the result |
| conv_value | input | 16 | Calibrated reading |
| thr_cfg | input | 384 | Four 16-bit thresholds per channel |
| rshift_cfg | input | 12 | Right-shift counts for the four monitor channels |
| alarm_en | input | 16 | Alarm enable mask, one byte per transmitter |
| warn_en | input | 16 | Warning enable mask, one byte per transmitter |
| alarm_latch | input | 2 | Sticky alarm request per transmitter |
| warn_latch | input | 2 | Sticky warning request per transmitter |
| req_clr | input | 2 | Clears the sticky requests of a transmitter |
| alarm_flags | output | 16 | Alarm flag byte per transmitter |
| warn_flags | output | 16 | Warning flag byte per transmitter |
| ready_flags | output | 8 | Ready nibble per transmitter |
| mon_values | output | 96 | Stored reading per channel |
| alarm_req | output | 2 | Alarm fault request per transmitter |
| warn_req | output | 2 | Warning fault request per transmitter |

## Verification
The bench builds the block with its default DATA_W of 16 and SHIFT_W of 3. With these widths the sign bit of the temperature word is bit 15. A reading such as F000h therefore shows whether a channel is compared signed or unsigned: signed, F000h sets the low flags; unsigned, it would set the high flags. The 3-bit shift counts allow shifts of 1 and 2 that pull a near-full-scale power reading back inside its window. The thresholds are chosen so that readings land exactly on them, just past them, and on either side of the sign boundary.

// File: rtl/mon_flag_pkg.sv
package mon_flag_pkg;

    localparam int NUM_CHAN = 6;
    localparam int NUM_TX   = 2;
    localparam int NUM_KIND = 4;
    localparam int CHAN_W   = 3;

    // Channel codes carried on conv_chan
    typedef enum logic [CHAN_W-1:0] {
        CH_TEMP  = 3'd0,
        CH_VCC   = 3'd1,
        CH_BIAS0 = 3'd2,
        CH_PWR0  = 3'd3,
        CH_BIAS1 = 3'd4,
        CH_PWR1  = 3'd5
    } chan_e;

    // Threshold slot order inside one channel's configuration word
    typedef enum int {
        K_ALM_HI = 0,
        K_ALM_LO = 1,
        K_WRN_HI = 2,
        K_WRN_LO = 3
    } kind_e;

    typedef struct packed {
        logic a_hi;
        logic a_lo;
        logic w_hi;
        logic w_lo;
    } flag_set_t;

endpackage

// File: rtl/mon_chan_unit.sv
module mon_chan_unit
    import mon_flag_pkg::*;
#(
    parameter int DATA_W     = 16,
    parameter int SHIFT_W    = 3,
    parameter bit SIGNED_CMP = 1'b0
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       stb,
    input  logic [DATA_W-1:0]          value,
    input  logic [SHIFT_W-1:0]         shamt,
    input  logic [NUM_KIND*DATA_W-1:0] thr,
    output flag_set_t                  flags,
    output logic [DATA_W-1:0]          stored,
    output logic                       ready
);

    logic [DATA_W-1:0] adj;
    logic [DATA_W-1:0] t_ahi, t_alo, t_whi, t_wlo;
    flag_set_t         cmp;

    assign adj   = value >> shamt;
    assign t_ahi = thr[int'(K_ALM_HI)*DATA_W +: DATA_W];
    assign t_alo = thr[int'(K_ALM_LO)*DATA_W +: DATA_W];
    assign t_whi = thr[int'(K_WRN_HI)*DATA_W +: DATA_W];
    assign t_wlo = thr[int'(K_WRN_LO)*DATA_W +: DATA_W];

    // R2 signed compare for temperature, R3 unsigned for the rest
    generate
        if (SIGNED_CMP) begin : g_signed
            always_comb begin
                cmp.a_hi = $signed(adj) > $signed(t_ahi);
                cmp.a_lo = $signed(adj) < $signed(t_alo);
                cmp.w_hi = $signed(adj) > $signed(t_whi);
                cmp.w_lo = $signed(adj) < $signed(t_wlo);
            end
        end else begin : g_unsigned
            always_comb begin
                cmp.a_hi = adj > t_ahi;
                cmp.a_lo = adj < t_alo;
                cmp.w_hi = adj > t_whi;
                cmp.w_lo = adj < t_wlo;
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            flags  <= '0;
            stored <= '0;
            ready  <= 1'b0;
        end else if (stb) begin
            flags  <= cmp;
            stored <= adj;
            ready  <= 1'b1;
        end
    end

    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (rst)
        !stb |=> ($stable(flags) && $stable(stored))); // R1
    AST_READY_SET: assert property (@(posedge clk) disable iff (rst)
        stb |=> ready); // R8
    AST_READY_KEEP: assert property (@(posedge clk) disable iff (rst)
        ready |=> ready); // R8

endmodule

// File: rtl/mon_fault_req.sv
module mon_fault_req #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [BYTE_W-1:0] flags,
    input  logic [BYTE_W-1:0] en,
    input  logic              latch,
    input  logic              clr,
    output logic              req
);

    logic hit;
    logic sticky;

    assign hit = |(flags & en);
    assign req = hit | (latch & sticky);

    always_ff @(posedge clk) begin
        if (rst || clr || !latch) begin
            sticky <= 1'b0;
        end else if (hit) begin
            sticky <= 1'b1;
        end
    end

    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (rst)
        (latch && req && !clr) |=> (req || !latch)); // R10
    AST_NO_REQ_UNLATCHED: assert property (@(posedge clk) disable iff (rst)
        (!latch && (flags & en) == '0) |-> !req); // R9

endmodule

// File: rtl/mon_thresh_flags.sv
module mon_thresh_flags
    import mon_flag_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int SHIFT_W = 3
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                conv_stb,
    input  logic [CHAN_W-1:0]                   conv_chan,
    input  logic [DATA_W-1:0]                   conv_value,
    input  logic [NUM_CHAN*NUM_KIND*DATA_W-1:0] thr_cfg,
    input  logic [(NUM_CHAN-2)*SHIFT_W-1:0]     rshift_cfg,
    input  logic [NUM_TX*8-1:0]                 alarm_en,
    input  logic [NUM_TX*8-1:0]                 warn_en,
    input  logic [NUM_TX-1:0]                   alarm_latch,
    input  logic [NUM_TX-1:0]                   warn_latch,
    input  logic [NUM_TX-1:0]                   req_clr,
    output logic [NUM_TX*8-1:0]                 alarm_flags,
    output logic [NUM_TX*8-1:0]                 warn_flags,
    output logic [NUM_TX*4-1:0]                 ready_flags,
    output logic [NUM_CHAN*DATA_W-1:0]          mon_values,
    output logic [NUM_TX-1:0]                   alarm_req,
    output logic [NUM_TX-1:0]                   warn_req
);

    localparam int BYTE_W   = 8;
    localparam int RDY_W    = 4;
    localparam int SLICE_W  = NUM_KIND*DATA_W;
    localparam int FIRST_SH = int'(CH_BIAS0);
    localparam int C_TEMP   = int'(CH_TEMP);
    localparam int C_VCC    = int'(CH_VCC);

    logic [NUM_CHAN-1:0] chan_stb;
    logic [NUM_CHAN-1:0] chan_rdy;
    flag_set_t           chan_flags [NUM_CHAN];
    logic [DATA_W-1:0]   chan_val   [NUM_CHAN];

    // One comparator unit per channel; monitors get a shift count (R7)
    generate
        for (genvar ch = 0; ch < NUM_CHAN; ch++) begin : g_chan
            logic [SHIFT_W-1:0] shamt;
            if (ch >= FIRST_SH) begin : g_sh
                assign shamt = rshift_cfg[(ch-FIRST_SH)*SHIFT_W +: SHIFT_W];
            end else begin : g_nosh
                assign shamt = '0;
            end

            assign chan_stb[ch] = conv_stb && (conv_chan == CHAN_W'(ch));

            mon_chan_unit #(
                .DATA_W    (DATA_W),
                .SHIFT_W   (SHIFT_W),
                .SIGNED_CMP(ch == C_TEMP)
            ) u_chan (
                .clk   (clk),
                .rst   (rst),
                .stb   (chan_stb[ch]),
                .value (conv_value),
                .shamt (shamt),
                .thr   (thr_cfg[ch*SLICE_W +: SLICE_W]),
                .flags (chan_flags[ch]),
                .stored(chan_val[ch]),
                .ready (chan_rdy[ch])
            );

            assign mon_values[ch*DATA_W +: DATA_W] = chan_val[ch];
        end
    endgenerate

    // Per-transmitter byte assembly (R6, R8) and fault requests (R9, R10)
    generate
        for (genvar t = 0; t < NUM_TX; t++) begin : g_tx
            localparam int BI = FIRST_SH + 2*t;
            localparam int PI = BI + 1;

            assign alarm_flags[t*BYTE_W +: BYTE_W] = {
                chan_flags[C_TEMP].a_hi, chan_flags[C_TEMP].a_lo,
                chan_flags[C_VCC].a_hi,  chan_flags[C_VCC].a_lo,
                chan_flags[BI].a_hi,     chan_flags[BI].a_lo,
                chan_flags[PI].a_hi,     chan_flags[PI].a_lo};

            assign warn_flags[t*BYTE_W +: BYTE_W] = {
                chan_flags[C_TEMP].w_hi, chan_flags[C_TEMP].w_lo,
                chan_flags[C_VCC].w_hi,  chan_flags[C_VCC].w_lo,
                chan_flags[BI].w_hi,     chan_flags[BI].w_lo,
                chan_flags[PI].w_hi,     chan_flags[PI].w_lo};

            assign ready_flags[t*RDY_W +: RDY_W] =
                {chan_rdy[C_TEMP], chan_rdy[C_VCC], chan_rdy[BI], chan_rdy[PI]};

            mon_fault_req #(.BYTE_W(BYTE_W)) u_alarm_req (
                .clk  (clk),
                .rst  (rst),
                .flags(alarm_flags[t*BYTE_W +: BYTE_W]),
                .en   (alarm_en[t*BYTE_W +: BYTE_W]),
                .latch(alarm_latch[t]),
                .clr  (req_clr[t]),
                .req  (alarm_req[t])
            );

            mon_fault_req #(.BYTE_W(BYTE_W)) u_warn_req (
                .clk  (clk),
                .rst  (rst),
                .flags(warn_flags[t*BYTE_W +: BYTE_W]),
                .en   (warn_en[t*BYTE_W +: BYTE_W]),
                .latch(warn_latch[t]),
                .clr  (req_clr[t]),
                .req  (warn_req[t])
            );
        end
    endgenerate

    AST_SHARED_BITS: assert property (@(posedge clk) disable iff (rst)
        alarm_flags[7:4] == alarm_flags[15:12]); // R6

endmodule

// File: tb/mon_thresh_flags_tb.sv
module mon_thresh_flags_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NCH = 6;
    localparam int NVEC = 14;

    logic         clk = 1'b0;
    logic         rst;
    logic         conv_stb;
    logic [2:0]   conv_chan;
    logic [15:0]  conv_value;
    logic [383:0] thr_cfg;
    logic [11:0]  rshift_cfg;
    logic [15:0]  alarm_en, warn_en;
    logic [1:0]   alarm_latch, warn_latch, req_clr;
    logic [15:0]  alarm_flags, warn_flags;
    logic [7:0]   ready_flags;
    logic [95:0]  mon_values;
    logic [1:0]   alarm_req, warn_req;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // model state
    logic [15:0] m_val [NCH];
    logic [3:0]  m_flg [NCH];
    logic        m_rdy [NCH];

    // {chan[3:0], value, expected stored, expected {a_hi,a_lo,w_hi,w_lo}}
    localparam logic [39:0] VEC [NVEC] = '{
        {4'd0, 16'h1900, 16'h1900, 4'h0},  // R2 inside window
        {4'd0, 16'h5001, 16'h5001, 4'hA},  // R4 just above high
        {4'd0, 16'h5000, 16'h5000, 4'h2},  // R4 equal to alarm high
        {4'd0, 16'hF000, 16'hF000, 4'h5},  // R2 negative reading below low
        {4'd0, 16'hF600, 16'hF600, 4'h1},  // R5 equal to alarm low
        {4'd1, 16'hE000, 16'hE000, 4'hA},  // R3 top bit set, unsigned high
        {4'd1, 16'h9000, 16'h9000, 4'h1},  // R5 equal to alarm low
        {4'd1, 16'h8FFF, 16'h8FFF, 4'h5},  // R5 below both lows
        {4'd2, 16'h7800, 16'h7800, 4'h2},  // R7 shift 0, warn high only
        {4'd3, 16'hFFFC, 16'h3FFF, 4'h0},  // R7 shift 2 pulls into window
        {4'd4, 16'h1000, 16'h0800, 4'h5},  // R7 shift 1 drops below lows
        {4'd5, 16'h9000, 16'h9000, 4'hA},  // R3 power high
        {4'd6, 16'hFFFF, 16'h0000, 4'h0},  // R1 unused code ignored
        {4'd7, 16'h0001, 16'h0000, 4'h0}   // R1 unused code ignored
    };

    mon_thresh_flags u_dut (
        .clk(clk), .rst(rst), .conv_stb(conv_stb), .conv_chan(conv_chan),
        .conv_value(conv_value), .thr_cfg(thr_cfg), .rshift_cfg(rshift_cfg),
        .alarm_en(alarm_en), .warn_en(warn_en), .alarm_latch(alarm_latch),
        .warn_latch(warn_latch), .req_clr(req_clr), .alarm_flags(alarm_flags),
        .warn_flags(warn_flags), .ready_flags(ready_flags), .mon_values(mon_values),
        .alarm_req(alarm_req), .warn_req(warn_req)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input logic [95:0] act, input logic [95:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic set_thr(input int ch, input logic [15:0] ahi, input logic [15:0] alo,
                           input logic [15:0] whi, input logic [15:0] wlo);
        thr_cfg[(ch*4+0)*16 +: 16] = ahi;
        thr_cfg[(ch*4+1)*16 +: 16] = alo;
        thr_cfg[(ch*4+2)*16 +: 16] = whi;
        thr_cfg[(ch*4+3)*16 +: 16] = wlo;
    endtask

    function automatic logic [15:0] exp_bytes(input bit warn);
        logic [15:0] r;
        for (int t = 0; t < 2; t++) begin
            int b = 2 + 2*t;
            int o = warn ? 0 : 2;
            r[t*8 +: 8] = {m_flg[0][o+1], m_flg[0][o], m_flg[1][o+1], m_flg[1][o],
                           m_flg[b][o+1], m_flg[b][o], m_flg[b+1][o+1], m_flg[b+1][o]};
        end
        return r;
    endfunction

    function automatic logic [7:0] exp_ready();
        logic [7:0] r;
        for (int t = 0; t < 2; t++) begin
            r[t*4 +: 4] = {m_rdy[0], m_rdy[1], m_rdy[2+2*t], m_rdy[3+2*t]};
        end
        return r;
    endfunction

    function automatic logic [95:0] exp_vals();
        logic [95:0] r;
        for (int c = 0; c < NCH; c++) r[c*16 +: 16] = m_val[c];
        return r;
    endfunction

    task automatic convert(input logic [2:0] ch, input logic [15:0] v);
        @(negedge clk);
        conv_stb = 1'b1; conv_chan = ch; conv_value = v;
        @(negedge clk);
        conv_stb = 1'b0;
    endtask

    task automatic check_all(input string tag);
        chk({tag, " R6 alarm bytes"}, 96'(alarm_flags), 96'(exp_bytes(1'b0)));
        chk({tag, " R6 warn bytes"},  96'(warn_flags),  96'(exp_bytes(1'b1)));
        chk({tag, " R7 stored values"}, mon_values, exp_vals());
        chk({tag, " R8 ready bits"}, 96'(ready_flags), 96'(exp_ready()));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL R11 watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; conv_stb = 1'b0; conv_chan = '0; conv_value = '0;
        thr_cfg = '0; alarm_en = '0; warn_en = '0;
        alarm_latch = '0; warn_latch = '0; req_clr = '0;
        set_thr(0, 16'h5000, 16'hF600, 16'h4600, 16'h0000);
        set_thr(1, 16'hD000, 16'h9000, 16'hC800, 16'h9800);
        for (int c = 2; c < NCH; c++) set_thr(c, 16'h8000, 16'h1000, 16'h7000, 16'h2000);
        rshift_cfg = {3'd0, 3'd1, 3'd2, 3'd0};
        for (int c = 0; c < NCH; c++) begin
            m_val[c] = '0; m_flg[c] = '0; m_rdy[c] = 1'b0;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R11 reset state
        check_all("R11 reset");
        chk("R11 requests after reset", 96'({alarm_req, warn_req}), 96'(0));

        // Vector table walk: R1 R2 R3 R4 R5 R6 R7 R8
        for (int i = 0; i < NVEC; i++) begin
            logic [3:0] ch;
            ch = VEC[i][39:36];
            convert(ch[2:0], VEC[i][35:20]);
            if (ch < 4'd6) begin
                m_val[ch] = VEC[i][19:4];
                m_flg[ch] = VEC[i][3:0];
                m_rdy[ch] = 1'b1;
            end
            check_all($sformatf("vec%0d R1", i));
        end
        chk("R8 all ready", 96'(ready_flags), 96'(8'hFF));

        // R9 masking; alarm bytes now 16h/10h, warn bytes 56h/58h
        @(negedge clk); alarm_en = 16'h0010; #1;
        chk("R9 enabled alarm raises request", 96'(alarm_req), 96'(2'b01));
        @(negedge clk); alarm_en = 16'h00EF; #1;
        chk("R9 masked alarm gives no request", 96'(alarm_req), 96'(2'b00));
        @(negedge clk); warn_en = 16'h0200; #1;
        chk("R9 enabled warning raises request", 96'(warn_req), 96'(2'b10));
        @(negedge clk); warn_en = 16'h0100; #1;
        chk("R9 masked warning gives no request", 96'(warn_req), 96'(2'b00));

        // R10 latched alarm on transmitter 1 (power high)
        @(negedge clk); alarm_en = 16'h0200; alarm_latch = 2'b10; #1;
        chk("R10 request raised", 96'(alarm_req), 96'(2'b10));
        convert(3'd5, 16'h5000);
        chk("R10 power flags cleared", 96'(alarm_flags[15:8]), 96'(8'h14));
        chk("R10 latched request holds", 96'(alarm_req), 96'(2'b10));
        @(negedge clk); req_clr = 2'b10;
        @(negedge clk); req_clr = 2'b00; #1;
        chk("R10 clear drops latched request", 96'(alarm_req), 96'(2'b00));

        // R10 unlatched warning on transmitter 0 (bias warn high)
        @(negedge clk); warn_en = 16'h0008; #1;
        chk("R10 unlatched request raised", 96'(warn_req), 96'(2'b01));
        convert(3'd2, 16'h3000);
        chk("R10 unlatched request follows flags", 96'(warn_req), 96'(2'b00));

        // R11 reset clears everything again
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        for (int c = 0; c < NCH; c++) begin
            m_val[c] = '0; m_flg[c] = '0; m_rdy[c] = 1'b0;
        end
        check_all("R11 second reset");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule